// File: doc/BRIEF.md
# Quad-channel converter register front end

This block is the digital register core that sits in front of four 12-bit digital-to-analog channels. A host drives a serial link made of a select line, a bit clock and a data line, plus two load strobes, a clear line and a clear-level select. All of these pins are sampled by a fast system clock through two-flop synchronizers. The block assembles 16-bit command words, decodes the 2-bit channel address in each word, and keeps two registers per channel: a staging (input) register and an output register that drives the converter.

The staging and output registers are level-transparent under two separate active-low strobes. That lets a host stage new codes for every channel without disturbing the outputs, and then move all four to the outputs at once. Holding the output strobe low makes each staged write appear at its output straight away. An asynchronous clear sets every staging and output register to zero-scale or mid-scale. It leaves the serial shift register untouched.

Top module: `quad_dac_regfile`

## Requirements
- R1: A command word is 16 bits sent most significant bit first. The first two bits received form the channel address. The next two are padding and have no effect. The last twelve are the channel code.
- R2: The shift register takes in one data bit on each rising edge of the logical OR of the select line and the bit clock, and changes at no other time. Either line can serve as the bit clock while the other is held low.
- R3: Address 00 selects channel 0, 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3. While the staging strobe is high, no staging register changes, and an unselected staging register never changes.
- R4: While the staging strobe is low, the selected staging register copies the code field of the shift register on every system clock.
- R5: While the output strobe is low, every output register copies its staging register on every system clock. While it is high, every output register holds.
- R6: While the clear line is low, every staging and output register is 12'h000 when clear-level select is 0 and 12'h800 when it is 1. The clear takes effect asynchronously.
- R7: The clear does not change the contents of the serial shift register.
- R8: After the clear is released, each register whose strobe is high keeps the clear value, and each register whose strobe is low resumes copying its source.
- R9: If bits are shifted while the staging strobe is low, the selected register follows the moving address and code bits. At the end of the word, the register addressed by the final word holds the final code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples every pin |
| sys_rst_n | input | 1 | Active-low reset of the synchronizers and shift logic |
| sel_n_i | input | 1 | Serial select, ORed with the bit clock |
| sck_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data |
| ld_in_n_i | input | 1 | Active-low staging strobe for the addressed channel |
| ld_all_n_i | input | 1 | Active-low strobe that moves all staging registers to the outputs |
| clr_n_i | input | 1 | Active-low asynchronous clear of staging and output registers |
| clr_mid_i | input | 1 | Clear level: 0 gives zero-scale, 1 gives mid-scale |
| dac_code_o | output | 48 | Output register codes, channel 0 in bits 11:0 up to channel 3 in bits 47:36 |

## Verification
On every cycle, the assertions check four things. The shift register moves only on a detected edge of the ORed serial clock. Staging registers hold unless they are selected with the staging strobe low. Output registers hold while the output strobe is high. Every register carries the clear code while the clear is active.

Some behaviour can only be shown by the bench's scenarios against its behavioural model. These are the word layout and the ignored padding bits, and swapping the roles of the select line and the bit clock. They also include survival of the shift contents across a clear, behaviour at clear release, and the corruption pattern when bits are shifted with the staging strobe held low.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Pin bundle as seen by the synchronizer stage.
    typedef struct packed {
        logic sel_n;
        logic sck;
        logic sdi;
        logic ldi_n;
        logic lda_n;
    } pin_bus_t;

    localparam int PIN_W = $bits(pin_bus_t);

    // Idle level: serial clock path high, both strobes latched.
    localparam pin_bus_t PIN_IDLE = '{sel_n: 1'b1, sck: 1'b1, sdi: 1'b0,
                                      ldi_n: 1'b1, lda_n: 1'b1};

endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] st;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.st[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.st[i] = sync_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.st <= {STAGES{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q.st[STAGES-1];

endmodule

// File: rtl/qdac_shift_front.sv
module qdac_shift_front #(
    parameter int ADDR_W = 2,
    parameter int PAD_W  = 2,
    parameter int CODE_W = 12,
    localparam int WORD_W = ADDR_W + PAD_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic              or_prev;
        logic [WORD_W-1:0] word;
    } shf_t;

    shf_t shf_d, shf_q;
    logic or_now;
    logic step;

    // Combined serial clock, edge-detected in the system clock domain.
    assign or_now = sel_n_i | sck_i;
    assign step   = or_now & ~shf_q.or_prev;

    always_comb begin
        shf_d         = shf_q;
        shf_d.or_prev = or_now;
        if (step) begin
            shf_d.word = {shf_q.word[WORD_W-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q.or_prev <= 1'b1;
            shf_q.word    <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign addr_o = shf_q.word[WORD_W-1 -: ADDR_W];
    assign code_o = shf_q.word[CODE_W-1:0];

    // The word only moves on a detected serial clock edge.
    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(or_now && !shf_q.or_prev) |=> $stable(shf_q.word));

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     clr_n_i,
    input  logic                     mid_i,
    input  logic                     ldi_n_i,
    input  logic                     lda_n_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic [NUM_CH*CODE_W-1:0] dac_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] inr;
        logic [NUM_CH-1:0][CODE_W-1:0] dac;
    } bank_t;

    bank_t bank_d, bank_q, bank_clr;
    logic [CODE_W-1:0] clr_code;

    assign clr_code = {mid_i, {(CODE_W-1){1'b0}}};

    always_comb begin
        bank_clr.inr = {NUM_CH{clr_code}};
        bank_clr.dac = {NUM_CH{clr_code}};
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!ldi_n_i && (addr_i == ADDR_W'(i))) begin
                bank_d.inr[i] = code_i;
            end
            if (!lda_n_i) begin
                bank_d.dac[i] = bank_q.inr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n_i) begin
        if (!clr_n_i) begin
            bank_q <= bank_clr;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign dac_o = bank_q.dac;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            // A staging register moves only when it is addressed with the strobe low.
            assert_in_hold_R3: assert property (@(posedge clk) disable iff (!clr_n_i)
                (ldi_n_i || (addr_i != ADDR_W'(g))) |=> $stable(bank_q.inr[g]));
        end
    endgenerate

    assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!clr_n_i)
        lda_n_i |=> $stable(bank_q.dac));

endmodule

// File: rtl/quad_dac_regfile.sv
module quad_dac_regfile #(
    parameter int NUM_CH      = 4,
    parameter int CODE_W      = 12,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(NUM_CH)
) (
    input  logic                     sys_clk,
    input  logic                     sys_rst_n,
    input  logic                     sel_n_i,
    input  logic                     sck_i,
    input  logic                     sdi_i,
    input  logic                     ld_in_n_i,
    input  logic                     ld_all_n_i,
    input  logic                     clr_n_i,
    input  logic                     clr_mid_i,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o
);

    import qdac_pkg::*;

    pin_bus_t pins_raw, pins_s;
    logic [ADDR_W-1:0] addr_w;
    logic [CODE_W-1:0] code_w;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] ff;
    } clr_t;

    clr_t clr_d, clr_q;
    logic clr_rst_n;

    assign pins_raw = '{sel_n: sel_n_i, sck: sck_i, sdi: sdi_i,
                        ldi_n: ld_in_n_i, lda_n: ld_all_n_i};

    qdac_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    // Clear: asserted at once, released through a synchronizer.
    always_comb begin
        clr_d.ff = SYNC_STAGES'({clr_q.ff, 1'b1});
    end

    always_ff @(posedge sys_clk or negedge clr_n_i) begin
        if (!clr_n_i) begin
            clr_q.ff <= '0;
        end else begin
            clr_q <= clr_d;
        end
    end

    assign clr_rst_n = clr_q.ff[SYNC_STAGES-1];

    qdac_shift_front #(
        .ADDR_W (ADDR_W),
        .PAD_W  (PAD_W),
        .CODE_W (CODE_W)
    ) u_shift (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .sel_n_i (pins_s.sel_n),
        .sck_i   (pins_s.sck),
        .sdi_i   (pins_s.sdi),
        .addr_o  (addr_w),
        .code_o  (code_w)
    );

    qdac_chan_bank #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk     (sys_clk),
        .clr_n_i (clr_rst_n),
        .mid_i   (clr_mid_i),
        .ldi_n_i (pins_s.ldi_n),
        .lda_n_i (pins_s.lda_n),
        .addr_i  (addr_w),
        .code_i  (code_w),
        .dac_o   (dac_code_o)
    );

    // Every output carries the clear code while the clear is held.
    assert_clear_code_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ($past(!clr_rst_n) && !clr_rst_n) |->
        (dac_code_o == {NUM_CH{{$past(clr_mid_i), {(CODE_W-1){1'b0}}}}}));

endmodule

// File: tb/quad_dac_regfile_tb_top.sv
module quad_dac_regfile_tb_top;

    localparam int NC = 4;
    localparam int CW = 12;

    typedef struct packed {
        logic sel, sck, sdi, ldi, lda;
    } pv_t;
    localparam pv_t IDLE = '{sel: 1'b1, sck: 1'b1, sdi: 1'b0, ldi: 1'b1, lda: 1'b1};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic sys_rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b1, sdi = 1'b0, ld_in_n = 1'b1, ld_all_n = 1'b1;
    logic clr_n = 1'b0, clr_mid = 1'b0;
    logic [NC*CW-1:0] dac_code;

    quad_dac_regfile dut_i (
        .sys_clk    (clk),
        .sys_rst_n  (sys_rst_n),
        .sel_n_i    (sel_n),
        .sck_i      (sck),
        .sdi_i      (sdi),
        .ld_in_n_i  (ld_in_n),
        .ld_all_n_i (ld_all_n),
        .clr_n_i    (clr_n),
        .clr_mid_i  (clr_mid),
        .dac_code_o (dac_code)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R6";
    bit done = 1'b0;

    // Behavioural reference model
    pv_t hist[4] = '{IDLE, IDLE, IDLE, IDLE};
    logic chist[3] = '{1'b0, 1'b0, 1'b0};
    logic [15:0] m_shift = '0;
    logic [CW-1:0] m_in[NC];
    logic [CW-1:0] m_dac[NC];

    always @(posedge clk) begin
        pv_t h2, h3;
        logic e;
        logic [15:0] ns;
        logic [CW-1:0] ni[NC];
        logic [CW-1:0] nd[NC];
        hist[3] = hist[2];
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = '{sel: sel_n, sck: sck, sdi: sdi, ldi: ld_in_n, lda: ld_all_n};
        chist[2] = chist[1];
        chist[1] = chist[0];
        chist[0] = clr_n;
        if (!sys_rst_n) begin
            for (int i = 0; i < 4; i++) hist[i] = IDLE;
        end
        h2 = hist[2];
        h3 = hist[3];
        e  = (h2.sel | h2.sck) & ~(h3.sel | h3.sck);
        ns = !sys_rst_n ? 16'h0000 : (e ? {m_shift[14:0], h2.sdi} : m_shift);
        ni = m_in;
        nd = m_dac;
        if (!h2.ldi) ni[m_shift[15:14]] = m_shift[11:0];
        if (!h2.lda) begin
            for (int i = 0; i < NC; i++) nd[i] = m_in[i];
        end
        if (!(chist[0] && chist[1] && chist[2])) begin
            for (int i = 0; i < NC; i++) begin
                ni[i] = {clr_mid, 11'h000};
                nd[i] = {clr_mid, 11'h000};
            end
        end
        m_shift = ns;
        m_in    = ni;
        m_dac   = nd;
        #1;
        if (!done) begin
            for (int i = 0; i < NC; i++) begin
                checks++;
                if (dac_code[i*CW +: CW] !== m_dac[i]) begin
                    fails++;
                    $display("FAIL %s model ch%0d actual %h expected %h", tag, i,
                             dac_code[i*CW +: CW], m_dac[i]);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ch(input int ch, input logic [CW-1:0] exp, input string req);
        checks++;
        if (dac_code[ch*CW +: CW] !== exp) begin
            fails++;
            $display("FAIL %s ch%0d actual %h expected %h", req, ch, dac_code[ch*CW +: CW], exp);
        end
    endtask

    task automatic send_sck(input logic [15:0] w);
        @(negedge clk) sel_n = 1'b0;
        wait_n(4);
        for (int b = 15; b >= 0; b--) begin
            sck = 1'b0;
            sdi = w[b];
            wait_n(4);
            sck = 1'b1;
            wait_n(4);
        end
        sel_n = 1'b1;
        wait_n(4);
    endtask

    task automatic send_sel(input logic [15:0] w);
        @(negedge clk) sck = 1'b0;
        wait_n(4);
        for (int b = 15; b >= 0; b--) begin
            sel_n = 1'b0;
            sdi = w[b];
            wait_n(4);
            sel_n = 1'b1;
            wait_n(4);
        end
        sck = 1'b1;
        wait_n(4);
    endtask

    task automatic pulse_in();
        @(negedge clk) ld_in_n = 1'b0;
        wait_n(4);
        ld_in_n = 1'b1;
        wait_n(6);
    endtask

    task automatic pulse_all();
        @(negedge clk) ld_all_n = 1'b0;
        wait_n(4);
        ld_all_n = 1'b1;
        wait_n(6);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        wait_n(5);
        sys_rst_n = 1'b1;
        wait_n(3);
        tag = "R6";
        for (int i = 0; i < NC; i++) expect_ch(i, 12'h000, "R6");
        clr_n = 1'b1;
        wait_n(5);

        // Stage channel 1, outputs must not move until the output strobe
        tag = "R3";
        send_sck({2'b01, 2'b00, 12'hABC});
        expect_ch(1, 12'h000, "R3");
        tag = "R5";
        pulse_in();
        expect_ch(1, 12'h000, "R5");
        tag = "R4";
        pulse_all();
        expect_ch(1, 12'hABC, "R4");
        expect_ch(0, 12'h000, "R3");

        // Select line used as the bit clock, padding bits set
        tag = "R2";
        send_sel({2'b10, 2'b11, 12'h5A5});
        pulse_in();
        pulse_all();
        expect_ch(2, 12'h5A5, "R2");
        expect_ch(1, 12'hABC, "R1");

        // Two more channels, moved together
        tag = "R1";
        send_sck({2'b00, 2'b10, 12'h123});
        pulse_in();
        send_sck({2'b11, 2'b01, 12'hFED});
        pulse_in();
        expect_ch(0, 12'h000, "R5");
        expect_ch(3, 12'h000, "R5");
        pulse_all();
        expect_ch(0, 12'h123, "R1");
        expect_ch(3, 12'hFED, "R1");

        // Output strobe held low: staging writes show at once
        tag = "R5";
        @(negedge clk) ld_all_n = 1'b0;
        send_sck({2'b00, 2'b00, 12'h777});
        pulse_in();
        expect_ch(0, 12'h777, "R5");
        @(negedge clk) ld_all_n = 1'b1;
        wait_n(6);

        // Clear to mid-scale keeps the shift contents
        tag = "R6";
        send_sck({2'b11, 2'b00, 12'h3C3});
        @(negedge clk) clr_mid = 1'b1;
        wait_n(2);
        clr_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < NC; i++) expect_ch(i, 12'h800, "R6");
        tag = "R8";
        clr_n = 1'b1;
        wait_n(10);
        for (int i = 0; i < NC; i++) expect_ch(i, 12'h800, "R8");
        tag = "R7";
        pulse_in();
        pulse_all();
        expect_ch(3, 12'h3C3, "R7");
        expect_ch(2, 12'h800, "R7");

        // Staging strobe low across clear release resumes copying
        tag = "R8";
        @(negedge clk) clr_mid = 1'b0;
        send_sck({2'b01, 2'b00, 12'h0F0});
        @(negedge clk) ld_in_n = 1'b0;
        wait_n(2);
        clr_n = 1'b0;
        wait_n(4);
        expect_ch(1, 12'h000, "R6");
        clr_n = 1'b1;
        wait_n(10);
        ld_in_n = 1'b1;
        wait_n(6);
        expect_ch(1, 12'h000, "R8");
        pulse_all();
        expect_ch(1, 12'h0F0, "R8");
        expect_ch(0, 12'h000, "R8");

        // Shifting with the staging strobe low
        tag = "R9";
        @(negedge clk) ld_in_n = 1'b0;
        send_sck({2'b11, 2'b00, 12'h9E1});
        @(negedge clk) ld_in_n = 1'b1;
        wait_n(6);
        pulse_all();
        expect_ch(3, 12'h9E1, "R9");

        wait_n(4);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule